// File: doc/BRIEF.md
# Preemptive Injected-Group Conversion Sequencer

This block sequences channel conversions for one master converter and up to two slave converters. Each converter steps through its own regular channel list. When the rising edge of the injected trigger arrives, every converter that is free drops its regular work and starts its injected channel list, and all of them do so in the same cycle. When a converter finishes its injected list, it goes back to its regular list at the channel that was cut short and converts that channel again from the start.

The trigger comes from a bank of trigger lines, and a 4-bit select field owned by the master picks which line is used. The analog conversion itself is outside the block. Each converter reports the end of a conversion with a one-cycle done strobe, and the block answers with the next start pulse, the channel number and a kind bit. A regular start request made while that converter's regular list is already running has no effect. A request made during an injected group is held and begins after the group ends.

Injected lists may differ in length between converters. If a new trigger arrives while the longest list is still running, the converters that have already finished start again while the others carry on, and the block raises a one-cycle flag when this happens. A configuration check reports when two converters in their injected groups are converting the same channel.

Top module: `inj_preempt_seq`

## Requirements
- R1: After reset, no start pulse is issued and every end-of-group flag, the skew flag and the clash flag read 0.
- R2: Only the trigger line whose index equals `trig_sel` can start injected groups; activity on any other line produces no start.
- R3: A trigger line held high starts exactly one injected group per converter. Only a 0-to-1 change counts.
- R4: When no converter is in an injected group, an accepted trigger starts the injected channel 0 on every converter in the same cycle.
- R5: An injected group converts channels 0 up to `inj_last` in order (`inj_last` holds the length minus 1 in 2 bits, so 1 to 4 channels). The next start follows each done strobe, and each injected start has `conv_inj`=1.
- R6: A regular sequence started by `reg_go` converts channels 0 up to `reg_last` in order (length minus 1 in 4 bits, so 1 to 16 channels), with `conv_inj`=0. With `cont_en` low it stops after one pass. With `cont_en` high it wraps to channel 0.
- R7: An accepted trigger abandons any regular conversion in progress on that converter. The very next start on that converter is injected.
- R8: After the injected group ends, regular sequencing resumes with the channel that was interrupted, and then continues in order.
- R9: `inj_eos`/`reg_eos` are set when an injected group or a regular pass completes. They stay set until a 1 is written to the matching clear input.
- R10: A trigger that arrives while some converters are still in their injected groups restarts only the converters that have finished. `inj_skew` pulses for one cycle.
- R11: `inj_clash` is high while two converters in injected groups are converting the same channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NTRIG | Trigger line bank |
| trig_sel | input | SEL_W | Master's injected trigger select |
| reg_go | input | NCONV | Start a regular sequence, one bit per converter |
| cont_en | input | NCONV | Continuous regular mode per converter |
| reg_chans | input | NCONV×RLEN×CH_W | Regular channel lists |
| reg_last | input | NCONV×RPW | Regular length minus one |
| inj_chans | input | NCONV×ILEN×CH_W | Injected channel lists |
| inj_last | input | NCONV×IPW | Injected length minus one |
| conv_done | input | NCONV | Conversion-done strobe from each converter |
| inj_eos_clr | input | NCONV | Write-one-to-clear for inj_eos |
| reg_eos_clr | input | NCONV | Write-one-to-clear for reg_eos |
| conv_start | output | NCONV | Start pulse per converter |
| conv_inj | output | NCONV | Kind of the current conversion, 1 = injected |
| conv_chan | output | NCONV×CH_W | Channel of the current conversion |
| inj_eos | output | NCONV | Injected group complete flag |
| reg_eos | output | NCONV | Regular pass complete flag |
| inj_skew | output | 1 | A converter restarted while another was still in its group |
| inj_clash | output | 1 | Two injected conversions on the same channel |

## Verification
The assertions take it for granted that a converter raises `conv_done` only while it has a conversion pending, and at most once for each start pulse. They also assume `trig_sel` stays fixed while triggers are in use. The bench models every converter with a fixed three-cycle delay that restarts whenever a new start pulse appears, so an abandoned conversion never produces a stray done. Triggers are raised right after a start pulse, so a done strobe never lands in the same cycle as an accepted trigger.

// File: rtl/inj_preempt_seq.sv
module inj_preempt_seq #(
  parameter int NCONV = 3,
  parameter int NTRIG = 16,
  parameter int SEL_W = 4,
  parameter int CH_W  = 5,
  parameter int RLEN  = 16,
  parameter int ILEN  = 4,
  localparam int RPW  = $clog2(RLEN),
  localparam int IPW  = $clog2(ILEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [NCONV-1:0] reg_go,
  input  logic [NCONV-1:0] cont_en,
  input  logic [NCONV-1:0][RLEN-1:0][CH_W-1:0] reg_chans,
  input  logic [NCONV-1:0][RPW-1:0] reg_last,
  input  logic [NCONV-1:0][ILEN-1:0][CH_W-1:0] inj_chans,
  input  logic [NCONV-1:0][IPW-1:0] inj_last,
  input  logic [NCONV-1:0] conv_done,
  input  logic [NCONV-1:0] inj_eos_clr,
  input  logic [NCONV-1:0] reg_eos_clr,
  output logic [NCONV-1:0] conv_start,
  output logic [NCONV-1:0] conv_inj,
  output logic [NCONV-1:0][CH_W-1:0] conv_chan,
  output logic [NCONV-1:0] inj_eos,
  output logic [NCONV-1:0] reg_eos,
  output logic inj_skew,
  output logic inj_clash
);

  logic trig_q;
  logic [NCONV-1:0] in_inj, busy;
  wire  trig_now  = trig_in[trig_sel];
  wire  trig_edge = trig_now & ~trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q   <= 1'b0;
      inj_skew <= 1'b0;
    end else begin
      trig_q   <= trig_now;
      inj_skew <= trig_edge && (in_inj != '0) && (in_inj != '1);
    end
  end

  for (genvar c = 0; c < NCONV; c++) begin : g_cv
    logic st_q, kind_q, busy_q, inj_q, ract_q, ieos_q, reos_q;
    logic [CH_W-1:0] ch_q;
    logic [RPW-1:0]  rpos_q;
    logic [IPW-1:0]  ipos_q;
    wire  arm  = reg_go[c] & ~ract_q;
    wire  take = trig_edge & ~inj_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= 1'b0; kind_q <= 1'b0; busy_q <= 1'b0; inj_q <= 1'b0;
        ract_q <= 1'b0; ieos_q <= 1'b0; reos_q <= 1'b0;
        ch_q <= '0; rpos_q <= '0; ipos_q <= '0;
      end else begin
        st_q <= 1'b0;
        if (inj_eos_clr[c]) ieos_q <= 1'b0;
        if (reg_eos_clr[c]) reos_q <= 1'b0;
        if (take) begin
          inj_q <= 1'b1; ipos_q <= '0;
          st_q <= 1'b1; kind_q <= 1'b1; busy_q <= 1'b1;
          ch_q <= inj_chans[c][0];
          if (arm) begin ract_q <= 1'b1; rpos_q <= '0; end
        end else if (inj_q) begin
          if (arm) begin ract_q <= 1'b1; rpos_q <= '0; end
          if (conv_done[c]) begin
            if (ipos_q == inj_last[c]) begin
              inj_q <= 1'b0; ieos_q <= 1'b1;
              if (ract_q) begin
                st_q <= 1'b1; kind_q <= 1'b0; ch_q <= reg_chans[c][rpos_q];
              end else if (reg_go[c]) begin
                st_q <= 1'b1; kind_q <= 1'b0; ch_q <= reg_chans[c][0];
              end else begin
                busy_q <= 1'b0;
              end
            end else begin
              ipos_q <= ipos_q + 1'b1;
              st_q <= 1'b1; kind_q <= 1'b1;
              ch_q <= inj_chans[c][ipos_q + 1'b1];
            end
          end
        end else if (ract_q && conv_done[c]) begin
          if (rpos_q == reg_last[c]) begin
            reos_q <= 1'b1;
            if (cont_en[c]) begin
              rpos_q <= '0;
              st_q <= 1'b1; kind_q <= 1'b0; ch_q <= reg_chans[c][0];
            end else begin
              ract_q <= 1'b0; busy_q <= 1'b0;
            end
          end else begin
            rpos_q <= rpos_q + 1'b1;
            st_q <= 1'b1; kind_q <= 1'b0;
            ch_q <= reg_chans[c][rpos_q + 1'b1];
          end
        end else if (arm) begin
          ract_q <= 1'b1; rpos_q <= '0;
          st_q <= 1'b1; kind_q <= 1'b0; busy_q <= 1'b1;
          ch_q <= reg_chans[c][0];
        end
      end
    end

    assign conv_start[c] = st_q;
    assign conv_inj[c]   = kind_q;
    assign conv_chan[c]  = ch_q;
    assign inj_eos[c]    = ieos_q;
    assign reg_eos[c]    = reos_q;
    assign in_inj[c]     = inj_q;
    assign busy[c]       = busy_q;
  end

  always_comb begin
    inj_clash = 1'b0;
    for (int i = 0; i < NCONV; i++)
      for (int j = i + 1; j < NCONV; j++)
        if (in_inj[i] && in_inj[j] && busy[i] && busy[j] && conv_chan[i] == conv_chan[j])
          inj_clash = 1'b1;
  end

endmodule

// File: rtl/inj_seq_chk.sv
module inj_seq_chk #(
  parameter int NCONV = 3
) (
  input logic clk,
  input logic rst_n,
  input logic trig_edge,
  input logic [NCONV-1:0] in_inj,
  input logic [NCONV-1:0] busy,
  input logic [NCONV-1:0] conv_start,
  input logic [NCONV-1:0] conv_inj,
  input logic [NCONV-1:0] conv_done,
  input logic [NCONV-1:0] reg_eos,
  input logic [NCONV-1:0] reg_eos_clr,
  input logic inj_skew
);

  AST_GROUPS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_inj == '0) |=> (in_inj == '0 || in_inj == '1)); // R4

  AST_SKEW_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    inj_skew |-> $past(trig_edge)); // R10

  for (genvar c = 0; c < NCONV; c++) begin : g_a
    AST_PREEMPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge && !in_inj[c]) |=> (conv_start[c] && conv_inj[c])); // R7

    AST_DONE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done[c] |-> busy[c]); // R5

    AST_EOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_eos[c]) |-> $past(reg_eos_clr[c])); // R9
  end

endmodule

bind inj_preempt_seq inj_seq_chk #(.NCONV(NCONV)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_edge(trig_edge), .in_inj(in_inj), .busy(busy),
  .conv_start(conv_start), .conv_inj(conv_inj), .conv_done(conv_done),
  .reg_eos(reg_eos), .reg_eos_clr(reg_eos_clr), .inj_skew(inj_skew)
);

// File: tb/tb_inj_preempt_seq.sv
module tb_inj_preempt_seq;
  localparam int NC = 3, CW = 5, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] trig_in = '0;
  logic [3:0]  trig_sel = 4'd5;
  logic [NC-1:0] reg_go = '0, cont_en = '0, conv_done = '0, inj_eos_clr = '0, reg_eos_clr = '0;
  logic [NC-1:0][15:0][CW-1:0] reg_chans;
  logic [NC-1:0][3:0] reg_last;
  logic [NC-1:0][3:0][CW-1:0] inj_chans;
  logic [NC-1:0][1:0] inj_last;
  logic [NC-1:0] conv_start, conv_inj, inj_eos, reg_eos;
  logic [NC-1:0][CW-1:0] conv_chan;
  logic inj_skew, inj_clash;

  inj_preempt_seq dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel),
    .reg_go(reg_go), .cont_en(cont_en), .reg_chans(reg_chans), .reg_last(reg_last),
    .inj_chans(inj_chans), .inj_last(inj_last), .conv_done(conv_done),
    .inj_eos_clr(inj_eos_clr), .reg_eos_clr(reg_eos_clr),
    .conv_start(conv_start), .conv_inj(conv_inj), .conv_chan(conv_chan),
    .inj_eos(inj_eos), .reg_eos(reg_eos), .inj_skew(inj_skew), .inj_clash(inj_clash)
  );

  int nvec = 0, nfail = 0, nstart = 0;
  bit clash_seen = 0;
  int cnt [NC];
  logic [CW:0] expq [NC][$];

  function automatic int rch(int c, int k); return c * 8 + k; endfunction
  function automatic int ich(int c, int k); return 20 + c * 4 + k; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int c, input bit inj, input int ch);
    expq[c].push_back({inj, CW'(ch)});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  always @(negedge clk) begin
    for (int c = 0; c < NC; c++) begin
      if (conv_start[c]) begin
        cnt[c] = LAT; conv_done[c] = 1'b0;
      end else if (cnt[c] == 1) begin
        conv_done[c] = 1'b1; cnt[c] = 0;
      end else begin
        conv_done[c] = 1'b0;
        if (cnt[c] > 0) cnt[c]--;
      end
      if (rst_n && conv_start[c]) begin
        nstart++;
        if (expq[c].size() == 0) chk(1'b0, "R6 unexpected start", int'({conv_inj[c], conv_chan[c]}), -1);
        else begin
          logic [CW:0] e;
          e = expq[c].pop_front();
          chk({conv_inj[c], conv_chan[c]} == e, e[CW] ? "R5 injected order" : "R6 regular order",
              int'({conv_inj[c], conv_chan[c]}), int'(e));
        end
      end
    end
    if (inj_clash) clash_seen = 1;
  end

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (expq[0].size() == 0 && expq[1].size() == 0 && expq[2].size() == 0) break;
    end
    repeat (12) @(negedge clk);
    chk(expq[0].size() + expq[1].size() + expq[2].size() == 0, "R6 missing starts",
        expq[0].size() + expq[1].size() + expq[2].size(), 0);
  endtask

  task automatic clear_flags();
    inj_eos_clr = '1; reg_eos_clr = '1;
    @(negedge clk);
    inj_eos_clr = '0; reg_eos_clr = '0;
  endtask

  task automatic fire();
    trig_in[5] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int base;
    for (int c = 0; c < NC; c++) begin
      cnt[c] = 0;
      for (int k = 0; k < 16; k++) reg_chans[c][k] = CW'(rch(c, k));
      for (int k = 0; k < 4; k++)  inj_chans[c][k] = CW'(ich(c, k));
      reg_last[c] = 4'd3; inj_last[c] = 2'd1;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(conv_start == '0, "R1 start", int'(conv_start), 0);
    chk({inj_eos, reg_eos, inj_skew, inj_clash} == '0, "R1 flags", int'({inj_eos, reg_eos}), 0);

    // R2: unselected line does nothing
    base = nstart;
    trig_in[3] = 1'b1; repeat (5) @(negedge clk); trig_in[3] = 1'b0; repeat (8) @(negedge clk);
    chk(nstart == base, "R2 unselected line", nstart - base, 0);

    // R6 single pass, 3 channels
    reg_last[0] = 4'd2;
    for (int k = 0; k < 3; k++) push(0, 0, rch(0, k));
    reg_go[0] = 1'b1; @(negedge clk); reg_go[0] = 1'b0;
    drain();
    chk(reg_eos[0] == 1'b1, "R9 reg_eos set", reg_eos[0], 1);
    chk(inj_eos == '0, "R9 inj_eos untouched", int'(inj_eos), 0);
    reg_eos_clr[0] = 1'b1; @(negedge clk); reg_eos_clr[0] = 1'b0;
    chk(reg_eos[0] == 1'b0, "R9 reg_eos cleared", reg_eos[0], 0);

    // R6 continuous wrap, 2 channels
    reg_last[1] = 4'd1;
    for (int p = 0; p < 2; p++) begin push(1, 0, rch(1, 0)); push(1, 0, rch(1, 1)); end
    cont_en[1] = 1'b1; reg_go[1] = 1'b1; @(negedge clk); reg_go[1] = 1'b0;
    do @(negedge clk); while (!reg_eos[1]);
    cont_en[1] = 1'b0;
    drain();
    clear_flags();

    // R7 R8 R4: preempt all at regular channel 1
    for (int c = 0; c < NC; c++) begin
      reg_last[c] = 4'd3;
      push(c, 0, rch(c, 0)); push(c, 0, rch(c, 1));
      push(c, 1, ich(c, 0)); push(c, 1, ich(c, 1));
      for (int k = 1; k < 4; k++) push(c, 0, rch(c, k));
    end
    reg_go = '1; @(negedge clk); reg_go = '0;
    do @(negedge clk); while (!(conv_start[0] && !conv_inj[0] && conv_chan[0] == CW'(rch(0, 1))));
    fire();
    chk(conv_start == 3'b111, "R4 simultaneous start", int'(conv_start), 7);
    chk(conv_inj == 3'b111, "R7 next start injected", int'(conv_inj), 7);
    trig_in[5] = 1'b0;
    do @(negedge clk); while (!(conv_start[0] && !conv_inj[0]));
    chk(conv_chan[0] == CW'(rch(0, 1)), "R8 resume channel", int'(conv_chan[0]), rch(0, 1));
    drain();
    chk(inj_eos == 3'b111, "R9 inj_eos set", int'(inj_eos), 7);
    chk(reg_eos == 3'b111, "R9 reg_eos after resume", int'(reg_eos), 7);
    clear_flags();
    chk({inj_eos, reg_eos} == '0, "R9 all cleared", int'({inj_eos, reg_eos}), 0);

    // R3: held line gives one group
    inj_last = '0;
    for (int c = 0; c < NC; c++) push(c, 1, ich(c, 0));
    base = nstart;
    trig_in[5] = 1'b1; repeat (30) @(negedge clk); trig_in[5] = 1'b0;
    drain();
    chk(nstart - base == 3, "R3 one group per edge", nstart - base, 3);
    clear_flags();

    // R10: unequal lengths, retrigger
    inj_last[1] = 2'd3;
    push(0, 1, ich(0, 0)); push(0, 1, ich(0, 0));
    push(2, 1, ich(2, 0)); push(2, 1, ich(2, 0));
    for (int k = 0; k < 4; k++) push(1, 1, ich(1, k));
    fire(); trig_in[5] = 1'b0;
    do @(negedge clk); while (!inj_eos[0]);
    fire();
    chk(inj_skew == 1'b1, "R10 skew flag", inj_skew, 1);
    chk(conv_start == 3'b101, "R10 finished ones restart", int'(conv_start), 5);
    trig_in[5] = 1'b0;
    @(negedge clk);
    chk(inj_skew == 1'b0, "R10 skew one cycle", inj_skew, 0);
    drain();
    clear_flags();

    // R11: same channel on two converters
    chk(!clash_seen, "R11 no clash with distinct channels", clash_seen, 0);
    inj_last = '0;
    inj_chans[0][0] = CW'(9); inj_chans[1][0] = CW'(9);
    push(0, 1, 9); push(1, 1, 9); push(2, 1, ich(2, 0));
    fire();
    chk(inj_clash == 1'b1, "R11 clash flag", inj_clash, 1);
    trig_in[5] = 1'b0;
    drain();
    chk(inj_clash == 1'b0, "R11 clash clears when idle", inj_clash, 0);

    summary();
    $finish;
  end
endmodule